// File: doc/BRIEF.md
# Watchdog Timer with Selectable Service Method

This block is a watchdog down-counter that software must service at regular intervals. Each pulse on the tick input, which comes from a periodic timer outside the block, lowers the counter by one. If the counter reaches zero before it is serviced, the block raises a single-cycle timeout pulse and the counter stays at zero.

A mode bit in the configuration register selects how the watchdog is serviced. With the mode bit clear, software services the watchdog by writing a new count into the count register. With the mode bit set, software services it by writing the key byte 5Ch into a separate key register. The counter then reloads from the count value written most recently.

Software reaches the registers through a plain write port made of an address, a data word and a write strobe. The current counter value is available on an output port, so that it can be observed.

Top module: `wdog_service`

## Requirements
- R1: After reset the mode bit is clear, the counter reads all ones (FFFFh at the default 16-bit width) and timeout is low.
- R2: Writes use address 0 for configuration (data bit 0 is the mode bit), address 1 for the count register and address 2 for the key register. A write to address 3, or any cycle with the write strobe low, changes nothing.
- R3: With the mode bit clear, a write to the count register loads the written value into the counter, and the new value is visible on the first cycle after the write.
- R4: With the mode bit clear, a write to the key register has no effect on the counter, even when the written value is 5Ch.
- R5: With the mode bit set, a write to the key register whose low 8 data bits equal 5Ch reloads the counter from the count value written most recently. The upper data bits are ignored.
- R6: With the mode bit set, a write to the count register leaves the counter unchanged. The written value is kept as the value for the next key reload.
- R7: With the mode bit set, a write to the key register whose low byte is not 5Ch leaves the counter unchanged.
- R8: Each tick-input pulse lowers a nonzero counter by exactly one.
- R9: A tick that takes the counter from 1 to 0 raises timeout for exactly one cycle. That cycle is the first cycle in which the counter reads zero.
- R10: Once at zero, the counter stays at zero through further ticks and raises no further timeout until it is serviced.
- R11: When a service and a tick fall in the same cycle, the service wins: the counter takes the service value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| tick | input | 1 | Decrement pulse from the periodic timer |
| count | output | 16 | Current counter value |
| timeout | output | 1 | One-cycle pulse when the counter reaches zero |

## Verification
Every register write and every tick is captured on one clock edge, and its result on count and timeout appears in the first cycle after that edge. No result takes two cycles. The bench changes its inputs on the falling edge and holds them through one rising edge. It then samples at the next falling edge, which is exactly the cycle in which the result is due. The timeout pulse is also sampled once more, one cycle later, to confirm that it has dropped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;
  localparam int KEY_W  = 8;
  localparam logic [KEY_W-1:0] SERVICE_KEY = 8'h5C;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_KEY  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadCount;       // service by direct count write
    logic storeReload;     // remember written count for key reloads
    logic reloadFromStore; // service by key match
    logic decrement;       // tick pulse
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  output wdogStrobe_t       strobe,
  output logic              modeKey
);
  regSel_e sel;
  logic    cfgWrite;
  logic    cntWrite;
  logic    keyWrite;
  logic    keyHit;

  assign sel      = regSel_e'(wrAddr);
  assign cfgWrite = wrEn && (sel == SEL_CFG);
  assign cntWrite = wrEn && (sel == SEL_CNT);
  assign keyWrite = wrEn && (sel == SEL_KEY);
  assign keyHit   = (wrData[KEY_W-1:0] == SERVICE_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeKey <= 1'b0;
    end else if (cfgWrite) begin
      modeKey <= wrData[0];
    end
  end

  always_comb begin
    strobe                 = '0;
    strobe.storeReload     = cntWrite;
    strobe.loadCount       = cntWrite && !modeKey;
    strobe.reloadFromStore = keyWrite && modeKey && keyHit;
    strobe.decrement       = tick;
  end

  // Only one service source may be active in a cycle
  p_one_service_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCount, strobe.reloadFromStore}));
  // Key path is closed while the mode bit is clear
  p_key_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && !modeKey) |-> !strobe.reloadFromStore);
  // Count writes do not service while the mode bit is set
  p_cnt_no_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrite && modeKey) |-> !strobe.loadCount);
  // Mode bit changes only through a configuration write
  p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> $stable(modeKey));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdogStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              timeout
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] countNext;
  logic             service;
  logic             hitZero;

  assign service = strobe.loadCount || strobe.reloadFromStore;
  assign hitZero = strobe.decrement && !service && (count == CNT_ONE);

  always_comb begin
    countNext = count;
    if (strobe.loadCount) begin
      countNext = wrData[CNT_W-1:0];
    end else if (strobe.reloadFromStore) begin
      countNext = reloadReg;
    end else if (strobe.decrement && (count != '0)) begin
      countNext = count - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadReg <= CNT_MAX;
      count     <= CNT_MAX;
      timeout   <= 1'b0;
    end else begin
      if (strobe.storeReload) begin
        reloadReg <= wrData[CNT_W-1:0];
      end
      count   <= countNext;
      timeout <= hitZero;
    end
  end

  p_timeout_at_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (count == '0));
  p_timeout_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);
  p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((count == '0) && !service) |=> ((count == '0) && !timeout));
  p_decrement_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decrement && !service && (count != '0)) |=> (count == $past(count) - CNT_ONE));
  p_key_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadFromStore |=> (count == $past(reloadReg)));
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!service && !strobe.decrement) |=> $stable(count));
endmodule

// File: rtl/wdog_service.sv
module wdog_service
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  output logic [CNT_W-1:0]  count,
  output logic              timeout
);
  wdogStrobe_t strobe;
  logic        modeKey;

  wdog_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .tick   (tick),
    .strobe (strobe),
    .modeKey(modeKey)
  );

  wdog_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .count  (count),
    .timeout(timeout)
  );
endmodule

// File: tb/sim_wdog_service.sv
module sim_wdog_service;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        tick = 1'b0;
  logic [15:0] count;
  logic        timeout;

  int vecs = 0;
  int bad  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_service u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tick(tick), .count(count), .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus; returns at the next falling edge, when results are due
  task automatic cycle(input bit we, input logic [1:0] a, input logic [15:0] d, input bit tk);
    wrEn = we; wrAddr = a; wrData = d; tick = tk;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cycle(1'b1, a, d, 1'b0);
  endtask

  task automatic do_tick();
    cycle(1'b0, 2'd0, 16'h0, 1'b1);
  endtask

  task automatic test_reset();
    check(count == 16'hFFFF, "R1", count, 16'hFFFF);
    check(timeout == 1'b0, "R1", timeout, 0);
    wr(2'd2, 16'h005C); // mode clear after reset, so key ignored
    check(count == 16'hFFFF, "R1", count, 16'hFFFF);
  endtask

  task automatic test_mode0_load();
    wr(2'd1, 16'h1234);
    check(count == 16'h1234, "R3", count, 16'h1234);
    wr(2'd1, 16'h0042);
    check(count == 16'h0042, "R3", count, 16'h0042);
    wr(2'd2, 16'h005C);
    check(count == 16'h0042, "R4", count, 16'h0042);
    wr(2'd2, 16'h00A7);
    check(count == 16'h0042, "R4", count, 16'h0042);
    wr(2'd3, 16'h0100);
    check(count == 16'h0042, "R2 addr3", count, 16'h0042);
    cycle(1'b0, 2'd1, 16'h0777, 1'b0);
    check(count == 16'h0042, "R2 no strobe", count, 16'h0042);
  endtask

  task automatic test_tick();
    wr(2'd1, 16'h0003);
    do_tick();
    check(count == 16'h0002, "R8", count, 2);
    check(timeout == 1'b0, "R9", timeout, 0);
    do_tick();
    check(count == 16'h0001, "R8", count, 1);
    do_tick();
    check(count == 16'h0000, "R9", count, 0);
    check(timeout == 1'b1, "R9", timeout, 1);
    @(negedge clk);
    check(timeout == 1'b0, "R9 pulse width", timeout, 0);
    do_tick();
    check(count == 16'h0000, "R10", count, 0);
    check(timeout == 1'b0, "R10", timeout, 0);
    do_tick();
    check(timeout == 1'b0, "R10", timeout, 0);
  endtask

  task automatic test_collision();
    cycle(1'b1, 2'd1, 16'h0010, 1'b1);
    check(count == 16'h0010, "R11 load", count, 16'h0010);
    wr(2'd0, 16'h0001);
    do_tick();
    check(count == 16'h000F, "R8", count, 16'h000F);
    cycle(1'b1, 2'd2, 16'h005C, 1'b1);
    check(count == 16'h0010, "R11 key", count, 16'h0010);
    wr(2'd0, 16'h0000);
  endtask

  task automatic test_mode1();
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'h0001);
    check(count == 16'h0020, "R2 cfg", count, 16'h0020);
    wr(2'd1, 16'h0008);
    check(count == 16'h0020, "R6", count, 16'h0020);
    do_tick();
    do_tick();
    check(count == 16'h001E, "R8", count, 16'h001E);
    wr(2'd2, 16'h005D);
    check(count == 16'h001E, "R7", count, 16'h001E);
    wr(2'd2, 16'h00C5);
    check(count == 16'h001E, "R7", count, 16'h001E);
    wr(2'd2, 16'hAB5C);
    check(count == 16'h0008, "R5", count, 16'h0008);
    for (int i = 0; i < 8; i++) do_tick();
    check(count == 16'h0000 && timeout, "R9 mode1", count, 0);
    do_tick();
    check(count == 16'h0000, "R10 mode1", count, 0);
    wr(2'd2, 16'h005C);
    check(count == 16'h0008, "R5 from zero", count, 16'h0008);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h005C);
    do_tick();
    check(count == 16'h0007, "R4 after clear", count, 16'h0007);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_mode0_load();
    test_tick();
    test_collision();
    test_mode1();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule